// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a simple request/ready host bus and one 4M x 16 asynchronous EDO DRAM. The DRAM has a multiplexed address bus. A 22-bit word address is split into a 12-bit row and a 10-bit column. These are presented one after the other on a shared 12-bit address pin group. The row is latched by a RAS# strobe and the column by a pair of byte-lane CAS# strobes.

The controller remembers which row is open. A later access to the same row is a page hit and gets only a column cycle. An access to another row first precharges, then activates the new row. Writes can cover a whole word or a single byte: only the lane strobes named by the byte enables are pulsed. Reads strobe both lanes and capture the data a set number of clocks after CAS falls. Every refresh interval an internal timer asks for one CAS-before-RAS refresh. That refresh takes priority over host traffic and closes any open row before it runs.

The host holds `req_valid` and its fields steady until `rsp_ready` pulses for one cycle. For reads, `rsp_rdata` is valid in that same cycle.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is held and just after it is released, RAS#, both CAS# lanes, WE# and OE# are high, the data bus is not driven and `rsp_ready` is low.
- R2: A host address maps as row = addr[21:10] and column = addr[9:0]. The row is on the address pins when RAS# falls, and the column is on them (bits 9:0) when CAS# falls.
- R3: For a write, WE# is already low in the cycle before the CAS strobes fall. WE# and OE# are never low together.
- R4: Byte enable bit 0 selects the low lane strobe (data bits 7:0) and bit 1 selects the high lane strobe (bits 15:8). A write pulses only the selected lanes, so unselected bytes keep their old value. A read pulses both lanes in the same cycle.
- R5: An access to the row that is already open issues no new RAS# fall.
- R6: An access to a different row raises RAS#, keeps it high for at least T_RP cycles, and then activates the new row.
- R7: Read data is sampled RD_LAT clocks after CAS# falls. Each access completes with a `rsp_ready` pulse exactly one cycle long, and accesses complete in request order.
- R8: A refresh drives both CAS# lanes low in the same cycle, before RAS# falls. One refresh is issued every REF_INTERVAL clocks.
- R9: A pending refresh is served before any new host request and leaves no row open. The first access after it therefore activates its row again.
- R10: The address pins hold steady while any CAS# lane stays low with RAS# low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request, held until rsp_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address {row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_ready |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Low-lane column strobe, active low |
| dram_cash_n | output | 1 | High-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | High while the controller drives the data bus |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The hardest situation to reach is a refresh landing between two accesses to the same row. The row that the host sees as open has been closed silently, so the next access has to reactivate it. To get there, the bench leaves a row open and then idles for many refresh intervals. It then re-reads that row and counts RAS# falls in its behavioural DRAM model. Page hits are checked in the same way: the bench confirms that no activation occurs between same-row accesses, all of which are issued well inside one refresh interval.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_CSET,
    ST_CAS,
    ST_DONE,
    ST_RCAS,
    ST_RRAS,
    ST_REND
  } edo_state_e;
endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  localparam int TW = $clog2(INTERVAL + 1);
  logic [TW-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0;
      pend <= 1'b0;
    end else begin
      if (ack) pend <= 1'b0;
      if (tick == TW'(INTERVAL - 1)) begin
        tick <= '0;
        pend <= 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
  parameter int ROW_W = 12,
  parameter int COL_W = 10
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [ROW_W-1:0]       open_row,
  input  logic                   row_open,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col,
  output logic                   hit
);
  assign row = addr[ROW_W+COL_W-1:COL_W];
  assign col = addr[COL_W-1:0];
  assign hit = row_open && (row == open_row);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 10,
  parameter int DATA_W       = 16,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int RD_LAT       = 1,
  parameter int REF_INTERVAL = 1560,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int LANE_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [PIN_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_casl_n,
  output logic              dram_cash_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int CNT_W = 8;

  edo_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic ref_pend, ref_ack, accept;
  logic [ROW_W-1:0] sp_row, open_row, lat_row, cur_row;
  logic [COL_W-1:0] sp_col, lat_col, cur_col;
  logic hit, row_open, row_open_d;
  logic lat_wr, cur_wr;
  logic [1:0] lat_be, cur_be;
  logic [DATA_W-1:0] lat_wdata, cur_wdata;

  edo_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend)
  );

  edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr(req_addr), .open_row(open_row), .row_open(row_open),
    .row(sp_row), .col(sp_col), .hit(hit)
  );

  // Sequencer: refresh outranks host traffic, open row kept after access
  always_comb begin
    state_d = state_q;
    ref_ack = 1'b0;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          if (row_open) state_d = ST_PRE;
          else begin
            state_d = ST_RCAS;
            ref_ack = 1'b1;
          end
        end else if (req_valid) begin
          accept = 1'b1;
          if (hit)           state_d = ST_CSET;
          else if (row_open) state_d = ST_PRE;
          else               state_d = ST_ACT;
        end
      end
      ST_PRE:  if (cnt == CNT_W'(T_RP - 1))  state_d = ST_IDLE;
      ST_ACT:  if (cnt == CNT_W'(T_RCD - 1)) state_d = ST_CSET;
      ST_CSET: state_d = ST_CAS;
      ST_CAS:  if (cnt == CNT_W'(T_CAS - 1)) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      ST_RCAS: state_d = ST_RRAS;
      ST_RRAS: if (cnt == CNT_W'(T_CAS - 1)) state_d = ST_REND;
      ST_REND: if (cnt == CNT_W'(T_RP - 1))  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Request fields as seen by the cycle being set up
  always_comb begin
    cur_row   = accept ? sp_row    : lat_row;
    cur_col   = accept ? sp_col    : lat_col;
    cur_wr    = accept ? req_write : lat_wr;
    cur_be    = accept ? req_be    : lat_be;
    cur_wdata = accept ? req_wdata : lat_wdata;
    row_open_d = row_open;
    if (state_d == ST_ACT && state_q != ST_ACT) row_open_d = 1'b1;
    if (state_d == ST_PRE || state_d == ST_RCAS) row_open_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt         <= '0;
      row_open    <= 1'b0;
      open_row    <= '0;
      lat_row     <= '0;
      lat_col     <= '0;
      lat_wr      <= 1'b0;
      lat_be      <= '0;
      lat_wdata   <= '0;
      dram_ras_n  <= 1'b1;
      dram_casl_n <= 1'b1;
      dram_cash_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rsp_ready   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      state_q  <= state_d;
      cnt      <= (state_d != state_q) ? '0 : cnt + 1'b1;
      row_open <= row_open_d;
      if (accept) begin
        lat_row   <= sp_row;
        lat_col   <= sp_col;
        lat_wr    <= req_write;
        lat_be    <= req_be;
        lat_wdata <= req_wdata;
      end
      if (state_d == ST_ACT) open_row <= cur_row;

      dram_ras_n <= !((state_d inside {ST_ACT, ST_CSET, ST_CAS, ST_DONE, ST_RRAS}) ||
                      (state_d == ST_IDLE && row_open_d));
      if (state_d == ST_ACT)
        dram_addr <= PIN_W'(cur_row);
      else if (state_d == ST_CSET)
        dram_addr <= PIN_W'(cur_col);

      if (state_d == ST_CAS) begin
        dram_casl_n <= cur_wr ? !cur_be[0] : 1'b0;
        dram_cash_n <= cur_wr ? !cur_be[1] : 1'b0;
      end else if (state_d == ST_RCAS || state_d == ST_RRAS) begin
        dram_casl_n <= 1'b0;
        dram_cash_n <= 1'b0;
      end else begin
        dram_casl_n <= 1'b1;
        dram_cash_n <= 1'b1;
      end

      dram_we_n   <= !(cur_wr && (state_d inside {ST_CSET, ST_CAS}));
      dram_oe_n   <= !(!cur_wr && (state_d inside {ST_CSET, ST_CAS}));
      dram_dq_oe  <= cur_wr && (state_d inside {ST_CSET, ST_CAS});
      dram_dq_out <= cur_wdata;
      rsp_ready   <= (state_d == ST_DONE);

      if (state_q == ST_CAS && cnt == CNT_W'(RD_LAT - 1) && !lat_wr) begin
        rsp_rdata[LANE_W-1:0]      <= dram_dq_in[LANE_W-1:0];
        rsp_rdata[DATA_W-1:LANE_W] <= dram_dq_in[DATA_W-1:LANE_W];
      end
    end
  end
endmodule

// File: rtl/edo_page_chk.sv
module edo_page_chk #(
  parameter int T_RP  = 2,
  parameter int PIN_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ras_n,
  input logic             casl_n,
  input logic             cash_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [PIN_W-1:0] addr,
  input logic             ready
);
  localparam int HW = 8;
  logic [HW-1:0] hi_cnt;
  logic any_cas;
  assign any_cas = !casl_n || !cash_n;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= HW'(T_RP);
    else if (!ras_n) hi_cnt <= '0;
    else if (hi_cnt != {HW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
  end

  // R3
  we_before_cas_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(any_cas) && !we_n) |-> $past(!we_n));
  // R3
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !oe_n));
  // R8
  cbr_both_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (any_cas && ras_n) |-> (!casl_n && !cash_n));
  // R8
  ras_fall_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (casl_n == cash_n));
  // R6
  precharge_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_cnt >= HW'(T_RP)));
  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (any_cas && !ras_n && $past(any_cas && !ras_n)) |-> $stable(addr));
endmodule

bind edo_page_ctrl edo_page_chk #(.T_RP(T_RP), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst(rst), .ras_n(dram_ras_n), .casl_n(dram_casl_n),
  .cash_n(dram_cash_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
  .addr(dram_addr), .ready(rsp_ready)
);

// File: tb/edo_page_ctrl_tb.sv
module edo_page_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TRP = 2;
  localparam int REFI = 2000;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic rsp_ready;
  logic [15:0] rsp_rdata, dram_dq_out;
  logic [11:0] dram_addr;
  logic dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_in = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_page_ctrl #(.T_RP(TRP), .T_RCD(2), .T_CAS(3), .RD_LAT(2), .REF_INTERVAL(REFI)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n), .dram_cash_n(dram_cash_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural DRAM model, sampled between edges
  logic [15:0] mem [int];
  int act_cnt = 0, ref_cnt = 0, proto_err = 0, hi_run = 100, min_hi = 100;
  logic [11:0] m_row = '0;
  logic [9:0]  m_col = '0;
  logic p_ras = 1, p_cl = 1, p_ch = 1, p_we = 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_ras && !dram_ras_n) begin
        if (!dram_casl_n && !dram_cash_n) ref_cnt++;
        else if (dram_casl_n && dram_cash_n) begin
          m_row = dram_addr;
          act_cnt++;
          if (hi_run < min_hi) min_hi = hi_run;
        end else proto_err++;
      end
      if (p_cl && p_ch && !(dram_casl_n && dram_cash_n)) begin
        if (!dram_ras_n) begin
          m_col = dram_addr[9:0];
          if (!dram_we_n) begin
            logic [15:0] w;
            if (p_we) proto_err++;
            w = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : 16'h0;
            if (!dram_casl_n) w[7:0]  = dram_dq_out[7:0];
            if (!dram_cash_n) w[15:8] = dram_dq_out[15:8];
            mem[int'({m_row, m_col})] = w;
          end
        end else if (dram_casl_n || dram_cash_n) proto_err++;
      end
      if (!dram_ras_n && !(dram_casl_n && dram_cash_n) && !dram_oe_n)
        dram_dq_in = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : 16'h0;
      else
        dram_dq_in = 16'h0;
      if (dram_ras_n) hi_run++; else hi_run = 0;
      p_ras = dram_ras_n; p_cl = dram_casl_n; p_ch = dram_cash_n; p_we = dram_we_n;
    end
  end

  // Scoreboard
  typedef struct { bit rd; logic [15:0] data; } exp_t;
  exp_t q[$];
  logic [15:0] ref_mem [int];
  bit prev_rdy = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_ready) begin
        chk(!prev_rdy, "R7 ready width", 32'(prev_rdy), 0);
        if (q.size() == 0) chk(0, "R7 unexpected ready", 1, 0);
        else begin
          exp_t it;
          it = q.pop_front();
          if (it.rd) chk(rsp_rdata === it.data, "R7/R4 read data", 32'(rsp_rdata), 32'(it.data));
        end
      end
      prev_rdy = rsp_ready;
    end
  end

  task automatic xfer(input bit wr, input logic [21:0] a, input logic [15:0] d, input logic [1:0] be);
    exp_t it;
    logic [15:0] cur;
    cur = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
    it.rd = !wr;
    it.data = cur;
    if (wr) begin
      if (be[0]) cur[7:0]  = d[7:0];
      if (be[1]) cur[15:8] = d[15:8];
      ref_mem[int'(a)] = cur;
    end
    q.push_back(it);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    do @(negedge clk); while (!rsp_ready);
    req_valid = 0;
  endtask

  localparam logic [21:0] A1 = {12'h123, 10'h045};
  localparam logic [21:0] A2 = {12'h123, 10'h3FF};
  localparam logic [21:0] A3 = {12'hABC, 10'h001};

  initial begin
    int a0, r0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(dram_ras_n && dram_casl_n && dram_cash_n, "R1 strobes in reset", {dram_ras_n, dram_casl_n, dram_cash_n}, 3'b111);
    rst = 0;
    @(negedge clk);
    chk(dram_ras_n && dram_casl_n && dram_cash_n, "R1 strobes after reset", {dram_ras_n, dram_casl_n, dram_cash_n}, 3'b111);
    chk(dram_we_n && dram_oe_n && !dram_dq_oe, "R1 we/oe/dq", {dram_we_n, dram_oe_n, dram_dq_oe}, 3'b110);
    chk(!rsp_ready, "R1 ready", 32'(rsp_ready), 0);

    xfer(1, A1, 16'hA5C3, 2'b11);
    // R2 row and column fields seen by DRAM
    chk(m_row == 12'h123, "R2 row latch", 32'(m_row), 32'h123);
    chk(m_col == 10'h045, "R2 col latch", 32'(m_col), 32'h045);
    a0 = act_cnt;
    xfer(0, A1, 0, 2'b11);
    chk(act_cnt == a0, "R5 page hit read", act_cnt - a0, 0);
    xfer(1, A2, 16'h0F1E, 2'b11);
    xfer(0, A2, 0, 2'b11);
    chk(act_cnt == a0, "R5 page hit same row", act_cnt - a0, 0);
    chk(m_col == 10'h3FF, "R2 top column", 32'(m_col), 32'h3FF);

    a0 = act_cnt;
    xfer(1, A3, 16'h5566, 2'b11);
    chk(act_cnt == a0 + 1, "R6 row miss activates", act_cnt - a0, 1);
    chk(m_row == 12'hABC, "R6 new row", 32'(m_row), 32'hABC);
    chk(min_hi >= TRP, "R6 precharge length", min_hi, TRP);

    // R4 byte lanes
    xfer(1, A3, 16'h99EE, 2'b10);
    xfer(0, A3, 0, 2'b11);
    xfer(1, A1, 16'h7734, 2'b01);
    xfer(0, A2, 0, 2'b11);
    xfer(0, A1, 0, 2'b11);

    // R8 refresh rate while idle, R9 row closed afterwards
    r0 = ref_cnt;
    repeat (20000) @(negedge clk);
    chk((ref_cnt - r0) >= 9 && (ref_cnt - r0) <= 11, "R8 refresh count", ref_cnt - r0, 10);
    chk(dram_ras_n, "R9 row closed after refresh", 32'(dram_ras_n), 1);
    a0 = act_cnt;
    xfer(0, A1, 0, 2'b11);
    chk(act_cnt == a0 + 1, "R9 reactivate after refresh", act_cnt - a0, 1);
    chk(proto_err == 0, "R3/R8 strobe protocol", proto_err, 0);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R7 all responses", q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule